// File: doc/BRIEF.md
# Shared-Bus Master Polling Scheduler

This block sits on the master side of a bus shared by several slave ports. Every clock cycle it puts one slave address on the bus and decodes it into that slave's own active-low chip enable. The addresses are visited in a fixed rotation. In the cycle after a slave is selected, that slave drives the shared status lines: "receive data available" and "transmit room available". The scheduler captures both lines and stores them in two per-slave bitmaps. One bitmap marks the slaves that are ready to be read, the other the slaves that are ready to be written.

When no transfer is outstanding, the scheduler picks a slave from the bitmaps and raises a request to an external data mover. The request carries a direction, a slave index and a fixed burst length. It stays raised until the mover returns a one-cycle done pulse. Reads take precedence over writes. Within a direction, service rotates so that the first ready slave after the one last served wins.

Polling never stops. The bitmaps keep filling while a burst is in flight, so the next decision is ready as soon as the bus is released.

Top module: `poll_sched_top`

## Requirements
- R1: `slv_ce_n` has exactly one bit low at all times. Bit i low selects slave i, and the low bit always matches `poll_addr`.
- R2: `poll_addr` advances by one every cycle and wraps from N_SLAVES-1 to 0. This continues whether or not a transfer is outstanding.
- R3: The flag values present in the cycle after slave i was selected are written into bit i of the maps. `rx_avail` goes to `rd_ready_map[i]` and `tx_room` goes to `wr_ready_map[i]`. The write takes place at the end of that cycle.
- R4: A read request (`xfer_dir`=1) is issued only to a slave whose read-ready bit is set. A write request (`xfer_dir`=0) is issued only to a slave whose write-ready bit is set.
- R5: Granting a transfer clears the granted slave's bit in the map of the granted direction. While that transfer is outstanding, poll samples do not update that one bit.
- R6: When both maps have a set bit at the moment of a decision, a read is granted.
- R7: Within the chosen direction, the winner is the first set bit found by counting upward from the last-served index plus one, wrapping at N_SLAVES.
- R8: `xfer_req` holds with stable `xfer_dir`, `xfer_slave` and `xfer_len` (= BURST_LEN) until `xfer_done` is seen. It is low in the following cycle. A `xfer_done` pulse while no request is outstanding has no effect.
- R9: During and right after reset, `xfer_req` is 0, both maps are 0 and `poll_addr` is 0. The last-served index starts at N_SLAVES-1, so slave 0 is first in line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slv_ce_n | output | N_SLAVES | Active-low per-slave chip enables (decoded poll address) |
| poll_addr | output | $clog2(N_SLAVES) | Slave address being polled |
| rx_avail | input | 1 | Shared flag: selected slave has receive data (valid the cycle after selection) |
| tx_room | input | 1 | Shared flag: selected slave has transmit room (valid the cycle after selection) |
| xfer_req | output | 1 | Transfer request to the data mover, held until done |
| xfer_dir | output | 1 | 1 = read from slave, 0 = write to slave |
| xfer_slave | output | $clog2(N_SLAVES) | Target slave of the request |
| xfer_len | output | $clog2(BURST_LEN+1) | Burst length in words |
| xfer_done | input | 1 | One-cycle pulse from the data mover ending the burst |
| rd_ready_map | output | N_SLAVES | Per-slave read-ready record |
| wr_ready_map | output | N_SLAVES | Per-slave write-ready record |

## Verification
The hardest state to reach from the ports is a decision made with several candidates pending in both directions. The rotation pointer has to sit at a chosen place for that test to mean anything. Polling fills the maps one slave per cycle, so an idle scheduler would grant the first bit that appears. The bench therefore holds a transfer open by withholding `done`. While the transfer is held, it raises flags on several slaves and lets polling record them. It then releases the bus and observes each grant in turn. This chain of held bursts covers read-over-write priority, wrap-around rotation and the masking of the active slave's bit.

// File: rtl/poll_sched_pkg.sv
package poll_sched_pkg;

  typedef enum logic {
    XDIR_WRITE = 1'b0,
    XDIR_READ  = 1'b1
  } xdir_e;

  typedef enum logic {
    ARB_IDLE = 1'b0,
    ARB_BUSY = 1'b1
  } arb_state_e;

  // next slot in a ring of n entries
  function automatic int slot_after(int cur, int n);
    return (cur + 1 >= n) ? 0 : cur + 1;
  endfunction

  // distance walked upward from 'from' to reach 'to' in a ring of n
  function automatic int ring_dist(int from, int to, int n);
    return (to > from) ? (to - from) : (to + n - from);
  endfunction

endpackage

// File: rtl/poll_seq.sv
module poll_seq
  import poll_sched_pkg::*;
#(
  parameter int N_SLAVES = 4,
  localparam int AW = (N_SLAVES > 1) ? $clog2(N_SLAVES) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic [AW-1:0]       poll_addr,
  output logic [N_SLAVES-1:0] ce_n,
  output logic                samp_vld,
  output logic [AW-1:0]       samp_idx
);

  logic [AW-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q    <= '0;
      samp_vld <= 1'b0;
      samp_idx <= '0;
    end else begin
      ptr_q    <= AW'(slot_after(int'(ptr_q), N_SLAVES));
      samp_vld <= 1'b1;
      samp_idx <= ptr_q;   // flags arrive one cycle after selection
    end
  end

  assign poll_addr = ptr_q;

  for (genvar g = 0; g < N_SLAVES; g++) begin : g_dec
    assign ce_n[g] = (ptr_q != AW'(g));
  end

endmodule

// File: rtl/ready_maps.sv
module ready_maps
  import poll_sched_pkg::*;
#(
  parameter int N_SLAVES = 4,
  localparam int AW = (N_SLAVES > 1) ? $clog2(N_SLAVES) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                samp_vld,
  input  logic [AW-1:0]       samp_idx,
  input  logic                rx_flag,
  input  logic                tx_flag,
  input  logic                busy,
  input  logic [AW-1:0]       act_idx,
  input  logic                act_dir,
  input  logic                grant,
  input  logic [AW-1:0]       grant_idx,
  input  logic                grant_dir,
  output logic [N_SLAVES-1:0] rd_map,
  output logic [N_SLAVES-1:0] wr_map
);

  for (genvar g = 0; g < N_SLAVES; g++) begin : g_slot
    logic rd_q, wr_q;
    logic hit, is_act, is_grant;

    assign hit      = samp_vld && (samp_idx == AW'(g));
    assign is_act   = busy && (act_idx == AW'(g));
    assign is_grant = grant && (grant_idx == AW'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rd_q <= 1'b0;
      end else if (is_grant && grant_dir == XDIR_READ) begin
        rd_q <= 1'b0;
      end else if (hit && !(is_act && act_dir == XDIR_READ)) begin
        rd_q <= rx_flag;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wr_q <= 1'b0;
      end else if (is_grant && grant_dir == XDIR_WRITE) begin
        wr_q <= 1'b0;
      end else if (hit && !(is_act && act_dir == XDIR_WRITE)) begin
        wr_q <= tx_flag;
      end
    end

    assign rd_map[g] = rd_q;
    assign wr_map[g] = wr_q;
  end

endmodule

// File: rtl/xfer_arbiter.sv
module xfer_arbiter
  import poll_sched_pkg::*;
#(
  parameter int N_SLAVES = 4,
  localparam int AW = (N_SLAVES > 1) ? $clog2(N_SLAVES) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_SLAVES-1:0] rd_map,
  input  logic [N_SLAVES-1:0] wr_map,
  input  logic                xfer_done,
  output logic                grant,
  output logic [AW-1:0]       grant_idx,
  output logic                grant_dir,
  output logic                busy,
  output logic [AW-1:0]       act_idx,
  output logic                act_dir
);

  arb_state_e    state_q;
  logic [AW-1:0] last_q;

  // {found, index}: first set bit walking upward from last+1
  function automatic logic [AW:0] rr_pick(logic [N_SLAVES-1:0] map, logic [AW-1:0] last);
    logic [AW:0] r;
    r = '0;
    for (int k = N_SLAVES; k >= 1; k--) begin
      int c;
      c = (int'(last) + k) % N_SLAVES;
      if (map[c]) r = {1'b1, AW'(c)};
    end
    return r;
  endfunction

  logic [AW:0] rd_pick, wr_pick;

  always_comb begin
    rd_pick   = rr_pick(rd_map, last_q);
    wr_pick   = rr_pick(wr_map, last_q);
    grant     = (state_q == ARB_IDLE) && (rd_pick[AW] || wr_pick[AW]);
    grant_dir = rd_pick[AW] ? XDIR_READ : XDIR_WRITE;
    grant_idx = rd_pick[AW] ? rd_pick[AW-1:0] : wr_pick[AW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ARB_IDLE;
      act_idx <= '0;
      act_dir <= XDIR_WRITE;
      last_q  <= AW'(N_SLAVES - 1);
    end else begin
      case (state_q)
        ARB_IDLE: if (grant) begin
          state_q <= ARB_BUSY;
          act_idx <= grant_idx;
          act_dir <= grant_dir;
          last_q  <= grant_idx;
        end
        ARB_BUSY: if (xfer_done) state_q <= ARB_IDLE;
        default:  state_q <= ARB_IDLE;
      endcase
    end
  end

  assign busy = (state_q == ARB_BUSY);

endmodule

// File: rtl/poll_sched_top.sv
module poll_sched_top
  import poll_sched_pkg::*;
#(
  parameter int N_SLAVES  = 4,
  parameter int BURST_LEN = 8,
  localparam int AW = (N_SLAVES > 1) ? $clog2(N_SLAVES) : 1,
  localparam int LW = $clog2(BURST_LEN + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic [N_SLAVES-1:0] slv_ce_n,
  output logic [AW-1:0]       poll_addr,
  input  logic                rx_avail,
  input  logic                tx_room,
  output logic                xfer_req,
  output logic                xfer_dir,
  output logic [AW-1:0]       xfer_slave,
  output logic [LW-1:0]       xfer_len,
  input  logic                xfer_done,
  output logic [N_SLAVES-1:0] rd_ready_map,
  output logic [N_SLAVES-1:0] wr_ready_map
);

  // named internal events
  logic          samp_vld;
  logic [AW-1:0] samp_idx;
  logic          grant;
  logic [AW-1:0] grant_idx;
  logic          grant_dir;
  logic          busy;
  logic [AW-1:0] act_idx;
  logic          act_dir;

  poll_seq #(.N_SLAVES(N_SLAVES)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .poll_addr (poll_addr),
    .ce_n      (slv_ce_n),
    .samp_vld  (samp_vld),
    .samp_idx  (samp_idx)
  );

  ready_maps #(.N_SLAVES(N_SLAVES)) u_maps (
    .clk       (clk),
    .rst_n     (rst_n),
    .samp_vld  (samp_vld),
    .samp_idx  (samp_idx),
    .rx_flag   (rx_avail),
    .tx_flag   (tx_room),
    .busy      (busy),
    .act_idx   (act_idx),
    .act_dir   (act_dir),
    .grant     (grant),
    .grant_idx (grant_idx),
    .grant_dir (grant_dir),
    .rd_map    (rd_ready_map),
    .wr_map    (wr_ready_map)
  );

  xfer_arbiter #(.N_SLAVES(N_SLAVES)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_map    (rd_ready_map),
    .wr_map    (wr_ready_map),
    .xfer_done (xfer_done),
    .grant     (grant),
    .grant_idx (grant_idx),
    .grant_dir (grant_dir),
    .busy      (busy),
    .act_idx   (act_idx),
    .act_dir   (act_dir)
  );

  assign xfer_req   = busy;
  assign xfer_dir   = act_dir;
  assign xfer_slave = act_idx;
  assign xfer_len   = LW'(BURST_LEN);

endmodule

// File: rtl/poll_sched_chk.sv
module poll_sched_chk
  import poll_sched_pkg::*;
#(
  parameter int N_SLAVES = 4,
  localparam int AW = (N_SLAVES > 1) ? $clog2(N_SLAVES) : 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic [N_SLAVES-1:0] ce_n,
  input logic [AW-1:0]       poll_addr,
  input logic                samp_vld,
  input logic [AW-1:0]       samp_idx,
  input logic                rx_flag,
  input logic                tx_flag,
  input logic [N_SLAVES-1:0] rd_map,
  input logic [N_SLAVES-1:0] wr_map,
  input logic                grant,
  input logic [AW-1:0]       grant_idx,
  input logic                grant_dir,
  input logic                xfer_req,
  input logic                xfer_dir,
  input logic [AW-1:0]       xfer_slave,
  input logic                xfer_done
);

  p_ce_decode_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_n[poll_addr] && ($countones(ce_n) == N_SLAVES - 1));

  p_poll_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ring_dist(int'($past(poll_addr)), int'(poll_addr), N_SLAVES) == 1));

  p_sample_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    samp_vld && !grant && !(xfer_req && xfer_dir && xfer_slave == samp_idx)
    |=> rd_map[$past(samp_idx)] == $past(rx_flag));

  p_sample_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    samp_vld && !grant && !(xfer_req && !xfer_dir && xfer_slave == samp_idx)
    |=> wr_map[$past(samp_idx)] == $past(tx_flag));

  p_grant_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (grant_dir ? rd_map[grant_idx] : wr_map[grant_idx]));

  p_grant_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    grant && grant_dir |=> !rd_map[$past(grant_idx)]);

  p_read_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    grant && (rd_map != '0) |-> grant_dir);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req && !xfer_done |=> xfer_req && $stable(xfer_slave) && $stable(xfer_dir));

  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req && xfer_done |=> !xfer_req);

endmodule

bind poll_sched_top poll_sched_chk #(.N_SLAVES(N_SLAVES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ce_n       (slv_ce_n),
  .poll_addr  (poll_addr),
  .samp_vld   (samp_vld),
  .samp_idx   (samp_idx),
  .rx_flag    (rx_avail),
  .tx_flag    (tx_room),
  .rd_map     (rd_ready_map),
  .wr_map     (wr_ready_map),
  .grant      (grant),
  .grant_idx  (grant_idx),
  .grant_dir  (grant_dir),
  .xfer_req   (xfer_req),
  .xfer_dir   (xfer_dir),
  .xfer_slave (xfer_slave),
  .xfer_done  (xfer_done)
);

// File: tb/tb_poll_sched_top.sv
module tb_poll_sched_top;

  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;
  localparam int BL = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] ce_n;
  logic [1:0] poll_addr;
  logic       rx_avail, tx_room;
  logic       xfer_req, xfer_dir;
  logic [1:0] xfer_slave;
  logic [3:0] xfer_len;
  logic       xfer_done = 1'b0;
  logic [3:0] rd_map, wr_map;

  // bench-side slave model
  logic [3:0] rx_src = '0;
  logic [3:0] tx_src = '0;
  logic [1:0] sel_q = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  poll_sched_top #(.N_SLAVES(NS), .BURST_LEN(BL)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .slv_ce_n     (ce_n),
    .poll_addr    (poll_addr),
    .rx_avail     (rx_avail),
    .tx_room      (tx_room),
    .xfer_req     (xfer_req),
    .xfer_dir     (xfer_dir),
    .xfer_slave   (xfer_slave),
    .xfer_len     (xfer_len),
    .xfer_done    (xfer_done),
    .rd_ready_map (rd_map),
    .wr_ready_map (wr_map)
  );

  function automatic logic [1:0] which_low(logic [3:0] v);
    logic [1:0] r;
    r = '0;
    for (int i = 0; i < 4; i++) if (!v[i]) r = 2'(i);
    return r;
  endfunction

  // selected slave answers one cycle after its enable was seen
  always @(posedge clk) sel_q <= which_low(ce_n);
  assign rx_avail = rx_src[sel_q];
  assign tx_room  = tx_src[sel_q];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic wait_req();
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (xfer_req) break;
    end
  endtask

  task automatic expect_grant(input bit dir, input int slv, input string req);
    wait_req();
    chk(xfer_req == 1'b1, req, int'(xfer_req), 1);
    chk(xfer_dir == dir, req, int'(xfer_dir), int'(dir));
    chk(int'(xfer_slave) == slv, req, int'(xfer_slave), slv);
    chk(int'(xfer_len) == BL, "R8", int'(xfer_len), BL);
  endtask

  task automatic pulse_done();
    @(negedge clk) xfer_done = 1'b1;
    @(negedge clk) xfer_done = 1'b0;
    chk(xfer_req == 1'b0, "R8", int'(xfer_req), 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(xfer_req == 1'b0, "R9", int'(xfer_req), 0);
    chk(rd_map == 4'h0 && wr_map == 4'h0, "R9", int'({rd_map, wr_map}), 0);
    chk(poll_addr == 2'd0, "R9", int'(poll_addr), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_poll_order();
    int prev;
    @(negedge clk);
    prev = int'(poll_addr);
    for (int i = 0; i < 9; i++) begin
      int exp;
      @(negedge clk);
      exp = (prev + 1) % NS;
      chk(int'(poll_addr) == exp, "R2", int'(poll_addr), exp);
      chk(ce_n == ~(4'b0001 << poll_addr), "R1", int'(ce_n), int'(~(4'b0001 << poll_addr)));
      prev = int'(poll_addr);
    end
  endtask

  task automatic t_idle();
    repeat (12) @(negedge clk);
    chk(xfer_req == 1'b0, "R4", int'(xfer_req), 0);
    chk(rd_map == 4'h0 && wr_map == 4'h0, "R3", int'({rd_map, wr_map}), 0);
  endtask

  task automatic t_first_read();
    rx_src[1] = 1'b1;
    expect_grant(1'b1, 1, "R4");
    chk(rd_map[1] == 1'b0, "R5", int'(rd_map[1]), 0);
  endtask

  task automatic t_poll_while_busy();
    int prev;
    rx_src[3] = 1'b1;
    tx_src[0] = 1'b1;
    tx_src[2] = 1'b1;
    prev = int'(poll_addr);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk(int'(poll_addr) == (prev + 1) % NS, "R2", int'(poll_addr), (prev + 1) % NS);
      prev = int'(poll_addr);
    end
    chk(xfer_req && xfer_slave == 2'd1 && xfer_dir, "R8", int'({xfer_req, xfer_slave}), 5);
    // bit 1 stays masked although its slave still reports data
    chk(rd_map == 4'b1000, "R5", int'(rd_map), 8);
    chk(wr_map == 4'b0101, "R3", int'(wr_map), 5);
  endtask

  task automatic t_read_priority();
    rx_src[1] = 1'b0;
    pulse_done();
    expect_grant(1'b1, 3, "R6");
    @(negedge clk);
    chk(rd_map == 4'b0000, "R5", int'(rd_map), 0);
    chk(wr_map == 4'b0101, "R6", int'(wr_map), 5);
  endtask

  task automatic t_rotation();
    rx_src[3] = 1'b0;
    repeat (6) @(negedge clk);
    pulse_done();
    expect_grant(1'b0, 0, "R7");
    @(negedge clk);
    chk(wr_map == 4'b0100, "R5", int'(wr_map), 4);
    tx_src[0] = 1'b0;
    repeat (6) @(negedge clk);
    pulse_done();
    expect_grant(1'b0, 2, "R7");
    rx_src[1] = 1'b1;
    rx_src[3] = 1'b1;
    tx_src[2] = 1'b0;
    repeat (10) @(negedge clk);
    pulse_done();
    expect_grant(1'b1, 3, "R7");
    rx_src[3] = 1'b0;
    repeat (6) @(negedge clk);
    pulse_done();
    expect_grant(1'b1, 1, "R7");
    rx_src[1] = 1'b0;
    repeat (6) @(negedge clk);
    pulse_done();
    repeat (12) @(negedge clk);
    chk(xfer_req == 1'b0, "R4", int'(xfer_req), 0);
    chk(rd_map == 4'h0 && wr_map == 4'h0, "R3", int'({rd_map, wr_map}), 0);
  endtask

  task automatic t_stray_done();
    pulse_done();
    repeat (4) @(negedge clk);
    chk(xfer_req == 1'b0, "R8", int'(xfer_req), 0);
    chk(rd_map == 4'h0 && wr_map == 4'h0, "R8", int'({rd_map, wr_map}), 0);
  endtask

  initial begin
    t_reset();
    t_poll_order();
    t_idle();
    t_first_read();
    t_poll_while_busy();
    t_read_priority();
    t_rotation();
    t_stray_done();
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

endmodule